// File: doc/BRIEF.md
# Monitor Conversion Sequencer and Result Formatter

This block drives one shared analog-to-digital converter that is multiplexed between a supply-voltage input and a sensed-current input. A 7-bit command word, written by the bus side, asks for continuous or one-shot conversion on each channel independently and carries a divider-range bit for the voltage front end. The sequencer starts conversions through a start/done handshake with a channel select and keeps the most recent result for each channel.

The read side sees an acknowledge-permit flag and a byte stream. A read transaction opens with a begin strobe, which freezes a snapshot of the results. Each next strobe then steps to the following byte. The frame is two or three bytes long. It carries the upper eight bits of each enabled channel, then the low nibbles. Which frame is used depends on the channels that the last command selected.

Top module: `mon_seq_top`

## Requirements
- R1: After a synchronous reset every command field is 0, `rd_ack` is 1, `vrange` and `stat_sel` are 0, `adc_start` is 0 and `rd_len` is 2.
- R2: Command bit positions: bit0 voltage continuous, bit1 voltage one-shot, bit2 current continuous, bit3 current one-shot, bit4 range select, bit5 unused, bit6 status select. `vrange` follows bit4 (0 = 14:1 divider, 1 = 7:2 divider) from the cycle after the write.
- R3: When both channels are enabled, the first conversion after a command write uses the voltage channel (`adc_chan` = 0). The following conversions alternate with current (`adc_chan` = 1).
- R4: `adc_start` is a one-cycle pulse. It is never raised while a conversion is still outstanding, including one abandoned by a command write; the result of an abandoned conversion is discarded.
- R5: A one-shot bit holds `rd_ack` at 0 from the cycle after the write until its conversion completes. The bit then clears itself, and no further conversion starts unless a continuous bit is set.
- R6: With only continuous bits set, `rd_ack` stays 1. A channel with no completed conversion reads back as zero bits.
- R7: With both channels selected, `rd_len` is 3 and the bytes are V[11:4], I[11:4], {V[3:0], I[3:0]}.
- R8: With one channel selected, `rd_len` is 2 and the bytes are X[11:4] and {X[3:0], 4'b0000}, where X is that channel. With neither channel selected, the voltage layout is used. A byte index past the frame length returns 8'h00.
- R9: All bytes of a transaction come from the results held at its begin strobe. Conversions that complete during the transaction do not change them.
- R10: A command write invalidates the stored result of each channel that it newly enables. A channel that was already enabled keeps its result.
- R11: `stat_sel` follows command bit6 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command write strobe |
| cmd_wr_data | input | 7 | Command word |
| adc_start | output | 1 | Conversion start pulse |
| adc_chan | output | 1 | Channel of the started conversion (0 voltage, 1 current) |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | 12 | Conversion result, valid with adc_done |
| vrange | output | 1 | Voltage divider range select |
| stat_sel | output | 1 | Status read select to the bus side |
| rd_ack | output | 1 | Reads may be acknowledged |
| rd_begin | input | 1 | Start of read transaction, freezes snapshot |
| rd_next | input | 1 | Advance to next read byte |
| rd_data | output | 8 | Current read byte |
| rd_len | output | 2 | Frame length in bytes (2 or 3) |

## Verification
The bench builds the block with its default 12-bit result width, the only width for which the nibble-split third byte fills exactly eight bits. Its converter model answers after six cycles. That short latency lets both channels alternate several times within a wait, so ordering and one-shot self-clearing can be checked by counting start pulses. The same latency also leaves a conversion in flight when a command is written, so discarded results, the retention of channels that were already enabled, and snapshot freezing during a slow read are all exercised.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  localparam int unsigned CB_VCONT = 0;
  localparam int unsigned CB_VONCE = 1;
  localparam int unsigned CB_ICONT = 2;
  localparam int unsigned CB_IONCE = 3;
  localparam int unsigned CB_RANGE = 4;
  localparam int unsigned CB_STAT  = 6;

  localparam logic CH_VOLT = 1'b0;
  localparam logic CH_CURR = 1'b1;
endpackage

// File: rtl/mon_cmd_reg.sv
module mon_cmd_reg
  import mon_pkg::*;
#(
  parameter int unsigned CMD_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             done_v,
  input  logic             done_i,
  output logic             v_cont,
  output logic             v_once,
  output logic             i_cont,
  output logic             i_once,
  output logic             range_q,
  output logic             stat_q,
  output logic             lay_v,
  output logic             lay_i,
  output logic             new_v,
  output logic             new_i
);
  logic wr_v, wr_i;

  assign wr_v  = wr_data[CB_VCONT] | wr_data[CB_VONCE];
  assign wr_i  = wr_data[CB_ICONT] | wr_data[CB_IONCE];
  assign new_v = wr_en & wr_v & ~(v_cont | v_once);
  assign new_i = wr_en & wr_i & ~(i_cont | i_once);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_cont  <= 1'b0;
      v_once  <= 1'b0;
      i_cont  <= 1'b0;
      i_once  <= 1'b0;
      range_q <= 1'b0;
      stat_q  <= 1'b0;
      lay_v   <= 1'b0;
      lay_i   <= 1'b0;
    end else if (wr_en) begin
      v_cont  <= wr_data[CB_VCONT];
      v_once  <= wr_data[CB_VONCE];
      i_cont  <= wr_data[CB_ICONT];
      i_once  <= wr_data[CB_IONCE];
      range_q <= wr_data[CB_RANGE];
      stat_q  <= wr_data[CB_STAT];
      lay_v   <= wr_v;
      lay_i   <= wr_i;
    end else begin
      if (done_v) v_once <= 1'b0;
      if (done_i) i_once <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_sched.sv
module mon_sched
  import mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic v_en,
  input  logic i_en,
  input  logic adc_done,
  output logic adc_start,
  output logic adc_chan,
  output logic done_v,
  output logic done_i
);
  seq_state_e st;
  logic       next_i;
  logic       pick_i;
  logic       acc;

  assign pick_i = i_en & (next_i | ~v_en);
  assign acc    = (st == SEQ_WAIT) & adc_done & ~restart;
  assign done_v = acc & (adc_chan == CH_VOLT);
  assign done_i = acc & (adc_chan == CH_CURR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_IDLE;
      next_i    <= 1'b0;
      adc_start <= 1'b0;
      adc_chan  <= CH_VOLT;
    end else begin
      adc_start <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (restart) begin
            next_i <= 1'b0;
          end else if (v_en | i_en) begin
            adc_start <= 1'b1;
            adc_chan  <= pick_i ? CH_CURR : CH_VOLT;
            st        <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (restart) begin
            next_i <= 1'b0;
            st     <= adc_done ? SEQ_IDLE : SEQ_DRAIN;
          end else if (adc_done) begin
            next_i <= (adc_chan == CH_VOLT);
            st     <= SEQ_IDLE;
          end
        end
        SEQ_DRAIN: begin
          if (restart)  next_i <= 1'b0;
          if (adc_done) st     <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mon_result.sv
module mon_result #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_v,
  input  logic              done_i,
  input  logic              new_v,
  input  logic              new_i,
  input  logic [DATA_W-1:0] adc_data,
  output logic [DATA_W-1:0] live_v,
  output logic [DATA_W-1:0] live_i
);
  logic [DATA_W-1:0] res_v, res_i;
  logic              val_v, val_i;

  assign live_v = val_v ? res_v : '0;
  assign live_i = val_i ? res_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_v <= '0;
      res_i <= '0;
      val_v <= 1'b0;
      val_i <= 1'b0;
    end else begin
      if (done_v) begin
        res_v <= adc_data;
        val_v <= 1'b1;
      end else if (new_v) begin
        val_v <= 1'b0;
      end
      if (done_i) begin
        res_i <= adc_data;
        val_i <= 1'b1;
      end else if (new_i) begin
        val_i <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mon_frame.sv
module mon_frame #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_begin,
  input  logic              rd_next,
  input  logic [DATA_W-1:0] live_v,
  input  logic [DATA_W-1:0] live_i,
  input  logic              lay_v,
  input  logic              lay_i,
  output logic [7:0]        rd_data,
  output logic [1:0]        rd_len
);
  localparam int unsigned LO_W = DATA_W - 8;
  localparam int unsigned PAD  = 8 - LO_W;

  logic [DATA_W-1:0] snap_v, snap_i;
  logic              snap_lv, snap_li;
  logic [1:0]        idx;

  function automatic logic [7:0] pack_byte(
    input logic [DATA_W-1:0] v,
    input logic [DATA_W-1:0] i,
    input logic              lv,
    input logic              li,
    input logic [1:0]        n
  );
    logic [DATA_W-1:0] x;
    logic [7:0]        b;
    x = (li & ~lv) ? i : v;
    b = 8'h00;
    if (lv & li) begin
      case (n)
        2'd0:    b = v[DATA_W-1 -: 8];
        2'd1:    b = i[DATA_W-1 -: 8];
        2'd2:    b = {v[LO_W-1:0], i[LO_W-1:0]};
        default: b = 8'h00;
      endcase
    end else begin
      case (n)
        2'd0:    b = x[DATA_W-1 -: 8];
        2'd1:    b = {x[LO_W-1:0], {PAD{1'b0}}};
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

  assign rd_len = (lay_v & lay_i) ? 2'd3 : 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_v  <= '0;
      snap_i  <= '0;
      snap_lv <= 1'b0;
      snap_li <= 1'b0;
      idx     <= 2'd0;
      rd_data <= 8'h00;
    end else if (rd_begin) begin
      snap_v  <= live_v;
      snap_i  <= live_i;
      snap_lv <= lay_v;
      snap_li <= lay_i;
      idx     <= 2'd1;
      rd_data <= pack_byte(live_v, live_i, lay_v, lay_i, 2'd0);
    end else if (rd_next) begin
      rd_data <= pack_byte(snap_v, snap_i, snap_lv, snap_li, idx);
      if (idx != 2'd3) idx <= idx + 2'd1;
    end
  end
endmodule

// File: rtl/mon_seq_top.sv
module mon_seq_top
  import mon_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CMD_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_en,
  input  logic [CMD_W-1:0]  cmd_wr_data,
  output logic              adc_start,
  output logic              adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              vrange,
  output logic              stat_sel,
  output logic              rd_ack,
  input  logic              rd_begin,
  input  logic              rd_next,
  output logic [7:0]        rd_data,
  output logic [1:0]        rd_len
);
  logic v_cont, v_once, i_cont, i_once;
  logic lay_v, lay_i, new_v, new_i;
  logic done_v, done_i;
  logic [DATA_W-1:0] live_v, live_i;

  mon_cmd_reg #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
    .done_v(done_v), .done_i(done_i),
    .v_cont(v_cont), .v_once(v_once), .i_cont(i_cont), .i_once(i_once),
    .range_q(vrange), .stat_q(stat_sel), .lay_v(lay_v), .lay_i(lay_i),
    .new_v(new_v), .new_i(new_i)
  );

  mon_sched u_sched (
    .clk(clk), .rst(rst), .restart(cmd_wr_en),
    .v_en(v_cont | v_once), .i_en(i_cont | i_once),
    .adc_done(adc_done), .adc_start(adc_start), .adc_chan(adc_chan),
    .done_v(done_v), .done_i(done_i)
  );

  mon_result #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst(rst), .done_v(done_v), .done_i(done_i),
    .new_v(new_v), .new_i(new_i), .adc_data(adc_data),
    .live_v(live_v), .live_i(live_i)
  );

  mon_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .rd_begin(rd_begin), .rd_next(rd_next),
    .live_v(live_v), .live_i(live_i), .lay_v(lay_v), .lay_i(lay_i),
    .rd_data(rd_data), .rd_len(rd_len)
  );

  assign rd_ack = ~(v_once | i_once);
endmodule

// File: rtl/mon_seq_chk.sv
module mon_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wr_en,
  input logic       adc_start,
  input logic       adc_done,
  input logic       vrange,
  input logic       stat_sel,
  input logic       rd_ack,
  input logic       rd_begin,
  input logic       rd_next,
  input logic [7:0] rd_data,
  input logic [1:0] rd_len
);
  logic busy;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (adc_start) busy <= 1'b1;
    else if (adc_done)  busy <= 1'b0;
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> !busy);

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ack) |-> ($past(adc_done) || $past(cmd_wr_en)));

  // R2
  range_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vrange) |-> $past(cmd_wr_en));

  // R11
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_sel) |-> $past(cmd_wr_en));

  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> ($past(rd_begin) || $past(rd_next)));

  // R7
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_len == 2'd2) || (rd_len == 2'd3));
endmodule

bind mon_seq_top mon_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .adc_start(adc_start),
  .adc_done(adc_done), .vrange(vrange), .stat_sel(stat_sel), .rd_ack(rd_ack),
  .rd_begin(rd_begin), .rd_next(rd_next), .rd_data(rd_data), .rd_len(rd_len)
);

// File: tb/mon_seq_top_bench.sv
`timescale 1ns/1ps
module mon_seq_top_bench;
  localparam int LAT  = 6;
  localparam int NVEC = 7;

  // {cmd[56:50], v[49:38], i[37:26], len[25:24], b0, b1, b2}
  localparam logic [56:0] VEC [NVEC] = '{
    {7'h01, 12'hABC, 12'h000, 2'd2, 8'hAB, 8'hC0, 8'h00},
    {7'h04, 12'h000, 12'h123, 2'd2, 8'h12, 8'h30, 8'h00},
    {7'h05, 12'h456, 12'h789, 2'd3, 8'h45, 8'h78, 8'h69},
    {7'h02, 12'hDEF, 12'h000, 2'd2, 8'hDE, 8'hF0, 8'h00},
    {7'h08, 12'h000, 12'h5A5, 2'd2, 8'h5A, 8'h50, 8'h00},
    {7'h0A, 12'h321, 12'h654, 2'd3, 8'h32, 8'h65, 8'h14},
    {7'h15, 12'h0F0, 12'hF0F, 2'd3, 8'h0F, 8'hF0, 8'h0F}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr_en = 1'b0;
  logic [6:0]  cmd_wr_data = '0;
  logic        adc_start, adc_chan;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic        vrange, stat_sel, rd_ack;
  logic        rd_begin = 1'b0, rd_next = 1'b0;
  logic [7:0]  rd_data;
  logic [1:0]  rd_len;

  int checks = 0;
  int errors = 0;
  logic [11:0] v_smp = '0, i_smp = '0;
  int   start_cnt = 0;
  logic chan_log [64];
  int   cnt = 0;
  logic ch_q = 1'b0;
  int   cycles = 0;

  always #5 clk = ~clk;

  mon_seq_top u_mon_seq_top (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
    .adc_data(adc_data), .vrange(vrange), .stat_sel(stat_sel), .rd_ack(rd_ack),
    .rd_begin(rd_begin), .rd_next(rd_next), .rd_data(rd_data), .rd_len(rd_len)
  );

  // converter model
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (rst) begin
      cnt <= 0;
    end else if (adc_start) begin
      cnt <= LAT;
      ch_q <= adc_chan;
      chan_log[start_cnt % 64] <= adc_chan;
      start_cnt <= start_cnt + 1;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        adc_done <= 1'b1;
        adc_data <= ch_q ? i_smp : v_smp;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [6:0] c);
    @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = c;
    @(negedge clk); cmd_wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic read_frame(output logic [7:0] b0, output logic [7:0] b1, output logic [7:0] b2);
    @(negedge clk); rd_begin = 1'b1;
    @(negedge clk); rd_begin = 1'b0; b0 = rd_data; rd_next = 1'b1;
    @(negedge clk); b1 = rd_data;
    @(negedge clk); rd_next = 1'b0; b2 = rd_data;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1, b2;
    int base;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_ack", rd_ack, 1);
    check("R1 vrange", vrange, 0);
    check("R1 stat_sel", stat_sel, 0);
    check("R1 adc_start", adc_start, 0);
    check("R1 rd_len", rd_len, 2);

    // table walk: R2 R7 R8 R5
    for (int n = 0; n < NVEC; n++) begin
      v_smp = VEC[n][49:38];
      i_smp = VEC[n][37:26];
      write_cmd(VEC[n][56:50]);
      check("R2 vrange", vrange, VEC[n][54]);
      wait_cyc(60);
      check("R5 rd_ack after completion", rd_ack, 1);
      check("R7/R8 rd_len", rd_len, VEC[n][25:24]);
      read_frame(b0, b1, b2);
      check("R7/R8 byte0", b0, VEC[n][23:16]);
      check("R7/R8 byte1", b1, VEC[n][15:8]);
      check("R7/R8 byte2", b2, VEC[n][7:0]);
    end

    // R5 one-shot refuses reads until done, then self clears
    v_smp = 12'h777;
    write_cmd(7'h02);
    check("R5 rd_ack low while pending", rd_ack, 0);
    wait_cyc(30);
    check("R5 rd_ack high after done", rd_ack, 1);
    base = start_cnt;
    wait_cyc(50);
    check("R5 no further starts", start_cnt, base);

    // R3 ordering voltage first then alternate
    write_cmd(7'h00);
    wait_cyc(20);
    base = start_cnt;
    write_cmd(7'h05);
    wait_cyc(40);
    check("R3 first chan", chan_log[base % 64], 0);
    check("R3 second chan", chan_log[(base + 1) % 64], 1);
    check("R3 third chan", chan_log[(base + 2) % 64], 0);

    // R10 + R6 newly enabled channel invalidated, old kept, ack and zeros
    v_smp = 12'h111; i_smp = 12'h999;
    write_cmd(7'h01);
    wait_cyc(40);
    write_cmd(7'h05);
    check("R6 rd_ack in continuous", rd_ack, 1);
    read_frame(b0, b1, b2);
    check("R10 kept voltage", b0, 8'h11);
    check("R6 R10 current zero", b1, 8'h00);
    check("R10 nibble byte", b2, 8'h10);

    // R6 from reset-like start: both newly enabled read zeros
    write_cmd(7'h00);
    wait_cyc(20);
    write_cmd(7'h05);
    read_frame(b0, b1, b2);
    check("R6 zero v", b0, 8'h00);
    check("R6 zero i", b1, 8'h00);

    // R9 snapshot frozen across conversions
    v_smp = 12'h222;
    write_cmd(7'h01);
    wait_cyc(40);
    @(negedge clk); rd_begin = 1'b1;
    @(negedge clk); rd_begin = 1'b0; b0 = rd_data;
    v_smp = 12'h999;
    wait_cyc(40);
    rd_next = 1'b1;
    @(negedge clk); rd_next = 1'b0; b1 = rd_data;
    check("R9 byte0", b0, 8'h22);
    check("R9 byte1 frozen", b1, 8'h20);
    read_frame(b0, b1, b2);
    check("R9 new read sees update", b0, 8'h99);

    // R4 restart during conversion discards in-flight result
    v_smp = 12'h333;
    write_cmd(7'h01);
    wait_cyc(40);
    v_smp = 12'hEEE;
    @(negedge clk);
    wait (adc_start == 1'b1);
    @(negedge clk);
    write_cmd(7'h00);
    wait_cyc(20);
    read_frame(b0, b1, b2);
    check("R4 abandoned result dropped", b0, 8'h33);

    // R11 status select
    write_cmd(7'h41);
    check("R11 stat_sel set", stat_sel, 1);
    write_cmd(7'h01);
    check("R11 stat_sel clear", stat_sel, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule